// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block turns one scalar instruction into a loop over vector elements. A start pulse loads a vector length, a predicate mask with its enable, a zeroing-mode bit, and, for each of the three operands (destination and two sources), a base register number and a flag that tags the operand as scalar or vector. The block then works through one element per clock. For each element it presents the destination and source register numbers, and it asks the register-file side to do one of three things: write the add result, write zero, or write nothing.

Each operand keeps its own offset. The offset of a vector operand moves to the next register after every element, and the offset of a scalar operand stays on its base register. When the destination is scalar, the loop stops after the first element that writes a real result. A sequence of masked-out elements before that element therefore moves the vector sources along, so the predicate selects which source element reaches the scalar result.

While the block is busy the program counter is held. A one-cycle done pulse releases it. The register file and the adder are outside the block.

Top module: `vsq_elem_seq`

## Requirements
- R1: A start pulse accepted in idle with a vector length N from 1 to 64 causes `busy` to be high from the next cycle, for one cycle per element. `elem_idx` counts 0, 1, 2 and so on in those cycles. `done` is high for exactly one cycle, the cycle after the last element, and `busy` is low in that cycle. `done` is low again in the cycle after that.
- R2: In element cycle i, a vector-tagged operand presents register (base + i) mod 128 and a scalar-tagged operand presents its base register. Bases and tags are captured at start.
- R3: When the effective predicate bit i is 1, element i drives `wr_valid`=1 and `wr_zero`=0 (an add result write).
- R4: When the effective predicate bit i is 0 and zeroing mode is off, element i drives `wr_valid`=0. The element still takes a cycle, and the vector offsets still advance.
- R5: When the effective predicate bit i is 0 and zeroing mode is on, element i drives `wr_valid`=1 and `wr_zero`=1 (a zero write).
- R6: With the predicate enable at 0, the mask input is ignored and every effective predicate bit is 1.
- R7: With a scalar destination, the loop ends after the first element whose effective predicate bit is 1. Zero writes and skipped elements do not end it. If no such bit exists, the loop runs all N elements.
- R8: A start with vector length 0 gives `done`=1 in the next cycle, with no element cycle and no write.
- R9: A start pulse while `busy` or `done` is high is ignored. The running loop and its captured settings are unchanged.
- R10: A vector length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop (taken only when idle) |
| vl | input | 7 | Vector length |
| pred_en | input | 1 | 1 = use pred_mask, 0 = all elements enabled |
| pred_mask | input | 64 | Bit i enables element i |
| zero_mode | input | 1 | Masked-out elements write zero |
| rd_base | input | 7 | Destination base register |
| rs1_base | input | 7 | First source base register |
| rs2_base | input | 7 | Second source base register |
| rd_vec | input | 1 | Destination tagged as vector |
| rs1_vec | input | 1 | First source tagged as vector |
| rs2_vec | input | 1 | Second source tagged as vector |
| busy | output | 1 | Element cycle in progress; PC held |
| done | output | 1 | One-cycle completion pulse; PC may advance |
| elem_idx | output | 7 | Current element number |
| wr_valid | output | 1 | Destination write this cycle |
| wr_zero | output | 1 | The write is zero, not the add result |
| rd_idx | output | 7 | Destination register number |
| rs1_idx | output | 7 | First source register number |
| rs2_idx | output | 7 | Second source register number |

## Verification
Random instructions mix all eight scalar/vector tag combinations with dense and sparse masks, both predicate-enable settings and both zeroing settings. This checks that the three offsets move independently and that the skip, add and zero actions are chosen per element.

Directed cases cover the following:
- A scalar destination behind leading zero bits, with zeroing off and on. This separates the two skip actions, and it separates the loop-ending add from the zero write, which does not end the loop.
- An all-zero mask with a scalar destination, which must run the full length.
- Lengths of 0 and 1, and a length above 64.
- Bases near 127, which check the register-number wraparound.
- Start pulses and scrambled inputs in the middle of a loop, which must not disturb it.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
    localparam int VL_MAX   = 64;
    localparam int VL_W     = 7;
    localparam int REG_W    = 7;
    localparam int NUM_OPND = 3;
    localparam int OP_RD    = 0;
    localparam int OP_RS1   = 1;
    localparam int OP_RS2   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vsq_state_e;

    typedef enum logic [1:0] {
        ACT_SKIP = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_ZERO = 2'd2
    } vsq_act_e;

    typedef struct packed {
        logic [VL_W-1:0] vl;
        logic            zero_mode;
        logic            rd_vec;
    } vsq_ctl_cfg_t;

    function automatic logic [VL_W-1:0] clamp_vl(input logic [VL_W-1:0] v);
        if (int'(v) > VL_MAX) return VL_W'(VL_MAX);
        return v;
    endfunction

    function automatic vsq_act_e pick_act(input logic bit_on, input logic zmode);
        if (bit_on) return ACT_ADD;
        if (zmode)  return ACT_ZERO;
        return ACT_SKIP;
    endfunction
endpackage

// File: rtl/vsq_opnd_ctr.sv
module vsq_opnd_ctr
    import vsq_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          is_vec,
    input  logic [RW-1:0] base,
    output logic [RW-1:0] idx,
    output logic          vec_q
);
    logic [RW-1:0] base_q;
    logic [RW-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            off_q  <= '0;
            vec_q  <= 1'b0;
        end else if (load) begin
            base_q <= base;
            off_q  <= '0;
            vec_q  <= is_vec;
        end else if (step && vec_q) begin
            off_q <= off_q + RW'(1);
        end
    end

    assign idx = base_q + off_q;
endmodule

// File: rtl/vsq_pred_sel.sv
module vsq_pred_sel
    import vsq_pkg::*;
#(
    parameter int NBITS = VL_MAX,
    parameter int EW    = VL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             pred_en,
    input  logic [NBITS-1:0] mask,
    input  logic [EW-1:0]    elem,
    output logic             cur_bit
);
    logic [NBITS-1:0] mask_q;
    localparam int SW = $clog2(NBITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= pred_en ? mask : {NBITS{1'b1}};
        end
    end

    assign cur_bit = mask_q[elem[SW-1:0]];
endmodule

// File: rtl/vsq_ctrl.sv
module vsq_ctrl
    import vsq_pkg::*;
#(
    parameter int EW = VL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [EW-1:0] vl,
    input  logic          zero_mode,
    input  logic          rd_vec,
    input  logic          cur_bit,
    output logic          load,
    output logic          step,
    output logic [EW-1:0] elem,
    output logic          busy,
    output logic          done,
    output logic          wr_valid,
    output logic          wr_zero,
    output logic          rd_vec_q
);
    vsq_state_e   state_q, state_d;
    vsq_ctl_cfg_t cfg_q;
    logic [EW-1:0] elem_q;
    vsq_act_e     act;
    logic         last;

    assign load = (state_q == ST_IDLE) && start;
    assign step = (state_q == ST_RUN);
    assign act  = pick_act(cur_bit, cfg_q.zero_mode);
    assign last = (elem_q == cfg_q.vl - EW'(1)) || (!cfg_q.rd_vec && cur_bit);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = (clamp_vl(vl) == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (last)  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            elem_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cfg_q.vl        <= clamp_vl(vl);
                cfg_q.zero_mode <= zero_mode;
                cfg_q.rd_vec    <= rd_vec;
                elem_q          <= '0;
            end else if (step) begin
                elem_q <= elem_q + EW'(1);
            end
        end
    end

    assign elem     = elem_q;
    assign busy     = (state_q == ST_RUN);
    assign done     = (state_q == ST_DONE);
    assign wr_valid = busy && (act != ACT_SKIP);
    assign wr_zero  = busy && (act == ACT_ZERO);
    assign rd_vec_q = cfg_q.rd_vec;
endmodule

// File: rtl/vsq_elem_seq.sv
module vsq_elem_seq
    import vsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic              pred_en,
    input  logic [VL_MAX-1:0] pred_mask,
    input  logic              zero_mode,
    input  logic [REG_W-1:0]  rd_base,
    input  logic [REG_W-1:0]  rs1_base,
    input  logic [REG_W-1:0]  rs2_base,
    input  logic              rd_vec,
    input  logic              rs1_vec,
    input  logic              rs2_vec,
    output logic              busy,
    output logic              done,
    output logic [VL_W-1:0]   elem_idx,
    output logic              wr_valid,
    output logic              wr_zero,
    output logic [REG_W-1:0]  rd_idx,
    output logic [REG_W-1:0]  rs1_idx,
    output logic [REG_W-1:0]  rs2_idx
);
    logic load, step, cur_bit, ctl_rd_vec;
    logic [NUM_OPND-1:0]            opnd_vec_in, opnd_vec_q;
    logic [NUM_OPND-1:0][REG_W-1:0] opnd_base, opnd_idx;

    assign opnd_vec_in = {rs2_vec, rs1_vec, rd_vec};
    assign opnd_base   = {rs2_base, rs1_base, rd_base};

    vsq_ctrl #(.EW(VL_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .vl(vl),
        .zero_mode(zero_mode), .rd_vec(rd_vec), .cur_bit(cur_bit),
        .load(load), .step(step), .elem(elem_idx), .busy(busy),
        .done(done), .wr_valid(wr_valid), .wr_zero(wr_zero),
        .rd_vec_q(ctl_rd_vec)
    );

    vsq_pred_sel #(.NBITS(VL_MAX), .EW(VL_W)) u_pred (
        .clk(clk), .rst(rst), .load(load), .pred_en(pred_en),
        .mask(pred_mask), .elem(elem_idx), .cur_bit(cur_bit)
    );

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        vsq_opnd_ctr #(.RW(REG_W)) u_ctr (
            .clk(clk), .rst(rst), .load(load), .step(step),
            .is_vec(opnd_vec_in[g]), .base(opnd_base[g]),
            .idx(opnd_idx[g]), .vec_q(opnd_vec_q[g])
        );
    end

    assign rd_idx  = opnd_idx[OP_RD];
    assign rs1_idx = opnd_idx[OP_RS1];
    assign rs2_idx = opnd_idx[OP_RS2];
endmodule

// File: rtl/vsq_elem_seq_chk.sv
module vsq_elem_seq_chk
    import vsq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                done,
    input logic [VL_W-1:0]     elem_idx,
    input logic                wr_valid,
    input logic                wr_zero,
    input logic [REG_W-1:0]    rd_idx,
    input logic [REG_W-1:0]    rs1_idx,
    input logic                ctl_rd_vec,
    input logic [NUM_OPND-1:0] opnd_vec_q
);
    // R1
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R1
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    // R1
    elem_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> elem_idx == $past(elem_idx) + VL_W'(1));
    // R1
    elem_start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> elem_idx == '0);
    // R2
    rd_vec_advance_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && opnd_vec_q[OP_RD] |-> rd_idx == $past(rd_idx) + REG_W'(1));
    // R2
    rs1_scalar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !opnd_vec_q[OP_RS1] |-> $stable(rs1_idx));
    // R5
    zero_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_zero |-> wr_valid);
    // R3
    write_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);
    // R7
    scalar_dest_stop_chk: assert property (@(posedge clk) disable iff (rst)
        busy && wr_valid && !wr_zero && !ctl_rd_vec |=> done);
endmodule

bind vsq_elem_seq vsq_elem_seq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .elem_idx(elem_idx),
    .wr_valid(wr_valid), .wr_zero(wr_zero), .rd_idx(rd_idx),
    .rs1_idx(rs1_idx), .ctl_rd_vec(ctl_rd_vec), .opnd_vec_q(opnd_vec_q)
);

// File: tb/vsq_elem_seq_tb_top.sv
module vsq_elem_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [6:0] vl = '0;
    logic pred_en = 1'b0;
    logic [63:0] pred_mask = '0;
    logic zero_mode = 1'b0;
    logic [6:0] rd_base = '0, rs1_base = '0, rs2_base = '0;
    logic rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
    logic busy, done, wr_valid, wr_zero;
    logic [6:0] elem_idx, rd_idx, rs1_idx, rs2_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vsq_elem_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .pred_en(pred_en),
        .pred_mask(pred_mask), .zero_mode(zero_mode), .rd_base(rd_base),
        .rs1_base(rs1_base), .rs2_base(rs2_base), .rd_vec(rd_vec),
        .rs1_vec(rs1_vec), .rs2_vec(rs2_vec), .busy(busy), .done(done),
        .elem_idx(elem_idx), .wr_valid(wr_valid), .wr_zero(wr_zero),
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_idx(input int base, input bit is_vec, input int i);
        return (base + (is_vec ? i : 0)) % 128;
    endfunction

    function automatic string act_tag(input bit pen, input bit mb, input bit z);
        if (!pen) return "R6";
        if (mb)   return "R3";
        return z ? "R5" : "R4";
    endfunction

    task automatic run_instr(input int vlen, input logic [63:0] m, input bit pen,
                             input bit z, input bit [2:0] vec, input int b0,
                             input int b1, input int b2, input bit poke);
        int n = (vlen > 64) ? 64 : vlen;
        string ltag = (vlen > 64) ? "R10" : "R7";
        @(negedge clk);
        vl = 7'(vlen); pred_mask = m; pred_en = pen; zero_mode = z;
        rd_vec = vec[0]; rs1_vec = vec[1]; rs2_vec = vec[2];
        rd_base = 7'(b0); rs1_base = 7'(b1); rs2_base = 7'(b2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            check("R8", "done after zero length", int'(done), 1);
            check("R8", "busy after zero length", int'(busy), 0);
            check("R8", "wr_valid after zero length", int'(wr_valid), 0);
        end else begin
            for (int i = 0; i < n; i++) begin
                bit mb = pen ? m[i] : 1'b1;
                string t = act_tag(pen, mb, z);
                check("R1", "busy", int'(busy), 1);
                check("R1", "elem_idx", int'(elem_idx), i);
                check(t, "wr_valid", int'(wr_valid), int'(mb | z));
                check(t, "wr_zero", int'(wr_zero), int'(!mb && z));
                check("R2", "rd_idx", int'(rd_idx), exp_idx(b0, vec[0], i));
                check("R2", "rs1_idx", int'(rs1_idx), exp_idx(b1, vec[1], i));
                check("R2", "rs2_idx", int'(rs2_idx), exp_idx(b2, vec[2], i));
                if (poke && i == 1) begin
                    start = 1'b1; vl = 7'd3; pred_mask = ~m; pred_en = ~pen;
                    zero_mode = ~z; rd_vec = ~vec[0]; rs1_vec = ~vec[1];
                    rs2_vec = ~vec[2]; rd_base = 7'd5; rs1_base = 7'd9; rs2_base = 7'd77;
                end
                if (i == n - 1 || (!vec[0] && mb)) break;
                @(negedge clk);
                start = 1'b0;
            end
            @(negedge clk);
            check(ltag, "done after last element", int'(done), 1);
            check(ltag, "busy after last element", int'(busy), 0);
            start = 1'b0;
        end
        @(negedge clk);
        check(poke ? "R9" : "R1", "done low after pulse", int'(done), 0);
        check(poke ? "R9" : "R1", "busy low after pulse", int'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "reset busy", int'(busy), 0);
        check("R1", "reset done", int'(done), 0);
        check("R3", "reset wr_valid", int'(wr_valid), 0);
        rst = 1'b0;
        // plain scalar instruction, length 1
        run_instr(1, 64'h0, 1'b0, 1'b0, 3'b000, 3, 4, 5, 1'b0);
        // R8 zero length
        run_instr(0, 64'hFFFF, 1'b1, 1'b1, 3'b111, 1, 2, 3, 1'b0);
        // R7 scalar dest, leading zero bits, zeroing off then on
        run_instr(10, 64'h8, 1'b1, 1'b0, 3'b010, 20, 30, 40, 1'b0);
        run_instr(10, 64'h8, 1'b1, 1'b1, 3'b110, 20, 30, 40, 1'b0);
        // R7 all-zero mask runs full length
        run_instr(6, 64'h0, 1'b1, 1'b0, 3'b110, 7, 8, 9, 1'b0);
        run_instr(6, 64'h0, 1'b1, 1'b1, 3'b010, 7, 8, 9, 1'b0);
        // R10 length above 64, R6 no predicate
        run_instr(100, 64'h0, 1'b0, 1'b1, 3'b111, 0, 64, 100, 1'b0);
        run_instr(64, 64'hA5A5_0F0F_3C3C_FF00, 1'b1, 1'b0, 3'b101, 126, 127, 90, 1'b0);
        // R9 start and input changes mid-loop
        run_instr(5, 64'h15, 1'b1, 1'b1, 3'b111, 10, 20, 30, 1'b1);
        run_instr(2, 64'h2, 1'b1, 1'b0, 3'b000, 11, 12, 13, 1'b1);
        for (int k = 0; k < 60; k++) begin
            int len = $urandom_range(0, 70);
            logic [63:0] m = {$urandom(), $urandom()};
            if ($urandom_range(0, 2) == 0) m = m & {$urandom(), $urandom()} & {$urandom(), $urandom()};
            run_instr(len, m, 1'($urandom()), 1'($urandom()), 3'($urandom()),
                      $urandom_range(0, 127), $urandom_range(0, 127),
                      $urandom_range(0, 127), ($urandom_range(0, 7) == 0));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule